// File: doc/BRIEF.md
# PHY-Side Control Bus Arbiter

This block sits at the physical-layer end of a shared control/data bus that connects a PHY to a link-layer controller. The bus has a 2-bit control field and a 4-bit data field, clocked by a 50 MHz interface clock that the PHY supplies. By default the PHY owns the bus and drives it, presenting idle, status, receive or grant codes. Status and receive traffic come from the PHY core as two valid/ready streams. A grant hands the bus to the link for exactly one cycle. The PHY then turns its drivers off and decodes what the link drives, which can be hold, transmit, or release. It takes the bus back after one turnaround cycle.

The same 2-bit code therefore means different things depending on who owns the bus. The number of live data lines follows a speed input. In narrow mode only the low two lines carry data, and the upper lines are held low.

Back-pressure rules for the inbound streams:
- A producer holds `valid`, its data and `last` steady until it sees `ready`.
- `ready` is high only while the block is in that stream's transfer state.
- One beat moves on each cycle in which both `valid` and `ready` are high.

The outbound transmit stream has no ready signal. The link cannot be stalled, so the consumer must take every beat that `tx_valid` marks.

Top module: `phy_ctl_arbiter`

## Requirements
- R1: After reset the block drives the bus (`bus_oe`=1) with control code 00 and all data lines 0. `rx_ready`, `stat_ready`, `tx_valid` and `link_err` are all 0.
- R2: Data lines are bits of `bus_dat_o`/`bus_dat_i`, and lines 0 and 1 are bits [1:0]. When `speed_fast`=1 all four bits carry data. When `speed_fast`=0, bits [3:2] are driven 0 on output and captured as 0 on `tx_data`.
- R3: While the PHY owns the bus, `bus_ctl_o` is 00 for idle, 01 for status, 10 for receive and 11 for grant. When more than one is pending in idle, receive wins over status, and status wins over grant. In idle and grant the data lines are 0.
- R4: A pending stream seen in idle moves the block into its transfer state on the next cycle. In that state the stream's `ready` is 1 and each valid beat appears masked on `bus_dat_o` in the same cycle. A cycle without `valid` keeps the code and drives data 0. A beat with `last` set returns the block to idle on the next cycle.
- R5: A grant is driven for exactly one cycle. From the next cycle `bus_oe` is 0 and the link owns the bus.
- R6: While the link owns the bus, code 01 (hold) and code 10 (transmit) keep ownership with the link. Each cycle of code 10 produces `tx_valid`=1 on the next cycle, with `tx_data` equal to the masked `bus_dat_i`.
- R7: Link code 00 (release) is followed by one turnaround cycle with `bus_oe`=0. The block then drives idle with `bus_oe`=1.
- R8: Link code 11 is an error. It raises `link_err` for one cycle on the next cycle, and the bus is reclaimed on the same timeline as a release.
- R9: While `bus_oe`=0, both `rx_ready` and `stat_ready` stay 0 and no transfer starts. A stream left pending is served once the bus returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_fast | input | 1 | 1: four data lines live, 0: two |
| rx_valid | input | 1 | Receive stream beat valid |
| rx_ready | output | 1 | Receive stream beat accepted |
| rx_data | input | 4 | Receive stream nibble |
| rx_last | input | 1 | Final receive beat |
| stat_valid | input | 1 | Status stream beat valid |
| stat_ready | output | 1 | Status stream beat accepted |
| stat_data | input | 4 | Status stream nibble |
| stat_last | input | 1 | Final status beat |
| grant_req | input | 1 | Hand the bus to the link |
| bus_ctl_o | output | 2 | Control code driven by the PHY |
| bus_dat_o | output | 4 | Data lines driven by the PHY |
| bus_oe | output | 1 | PHY output enable for control and data |
| bus_ctl_i | input | 2 | Control code seen on the bus |
| bus_dat_i | input | 4 | Data lines seen on the bus |
| tx_valid | output | 1 | Transmit nibble captured from the link |
| tx_data | output | 4 | Captured transmit nibble |
| link_err | output | 1 | One-cycle pulse on illegal link code 11 |

## Verification
The hardest case to reach is an illegal code 11 from the link. It requires a grant to win arbitration, which means no receive or status beat can be pending in idle. The link must then hold or transmit for a while, and the bad code must arrive before a release. The stimulus biases link codes towards hold and transmit, so link ownership lasts several cycles, and gives code 11 a small share of the draws. Directed sequences also place an error right after a grant, and place all three requests together in idle to exercise the priority order.

// File: rtl/phy_arb_pkg.sv
package phy_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STAT  = 3'd1,
    ST_RECV  = 3'd2,
    ST_GRANT = 3'd3,
    ST_LINK  = 3'd4,
    ST_TURN  = 3'd5
  } arb_state_t;

  localparam int CTL_W = 2;

  // codes while the PHY drives
  localparam logic [CTL_W-1:0] PHY_IDLE  = 2'b00;
  localparam logic [CTL_W-1:0] PHY_STAT  = 2'b01;
  localparam logic [CTL_W-1:0] PHY_RECV  = 2'b10;
  localparam logic [CTL_W-1:0] PHY_GRANT = 2'b11;

  // codes while the link drives
  localparam logic [CTL_W-1:0] LNK_DONE  = 2'b00;
  localparam logic [CTL_W-1:0] LNK_HOLD  = 2'b01;
  localparam logic [CTL_W-1:0] LNK_XMIT  = 2'b10;
  localparam logic [CTL_W-1:0] LNK_BAD   = 2'b11;
endpackage

// File: rtl/lane_mask.sv
module lane_mask #(
  parameter int DATA_W   = 4,
  parameter int NARROW_W = 2
) (
  input  logic [DATA_W-1:0] din,
  input  logic              wide,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i < NARROW_W) begin : g_always
      assign dout[i] = din[i];
    end else begin : g_wide_only
      assign dout[i] = din[i] & wide;
    end
  end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import phy_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_last,
  input  logic       stat_valid,
  input  logic       stat_last,
  input  logic       grant_req,
  input  logic       link_done,
  output arb_state_t state
);
  arb_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (rx_valid)        nxt = ST_RECV;
        else if (stat_valid) nxt = ST_STAT;
        else if (grant_req)  nxt = ST_GRANT;
      end
      ST_RECV:  if (rx_valid && rx_last)     nxt = ST_IDLE;
      ST_STAT:  if (stat_valid && stat_last) nxt = ST_IDLE;
      ST_GRANT: nxt = ST_LINK;
      ST_LINK:  if (link_done) nxt = ST_TURN;
      ST_TURN:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // a receive beat pending in idle always wins the next cycle
  assert_recv_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rx_valid) |=> (state == ST_RECV));
endmodule

// File: rtl/link_decode.sv
module link_decode
  import phy_arb_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_link,
  input  logic [CTL_W-1:0]  ctl_in,
  input  logic [DATA_W-1:0] dat_masked,
  output logic              link_done,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              link_err
);
  logic is_xmit, is_bad;

  assign is_xmit   = in_link && (ctl_in == LNK_XMIT);
  assign is_bad    = in_link && (ctl_in == LNK_BAD);
  assign link_done = in_link && ((ctl_in == LNK_DONE) || (ctl_in == LNK_BAD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      link_err <= 1'b0;
    end else begin
      tx_valid <= is_xmit;
      tx_data  <= is_xmit ? dat_masked : '0;
      link_err <= is_bad;
    end
  end

  // an error pulse never lasts two cycles
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |=> !link_err);
endmodule

// File: rtl/phy_ctl_arbiter.sv
module phy_ctl_arbiter
  import phy_arb_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int NARROW_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_fast,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_last,
  input  logic              stat_valid,
  output logic              stat_ready,
  input  logic [DATA_W-1:0] stat_data,
  input  logic              stat_last,
  input  logic              grant_req,
  output logic [1:0]        bus_ctl_o,
  output logic [DATA_W-1:0] bus_dat_o,
  output logic              bus_oe,
  input  logic [1:0]        bus_ctl_i,
  input  logic [DATA_W-1:0] bus_dat_i,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              link_err
);
  localparam int HI_W = DATA_W - NARROW_W;

  arb_state_t        state;
  logic              link_done;
  logic [DATA_W-1:0] out_raw, out_masked, in_masked;

  arb_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_last    (rx_last),
    .stat_valid (stat_valid),
    .stat_last  (stat_last),
    .grant_req  (grant_req),
    .link_done  (link_done),
    .state      (state)
  );

  lane_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_out_mask (
    .din  (out_raw),
    .wide (speed_fast),
    .dout (out_masked)
  );

  lane_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_in_mask (
    .din  (bus_dat_i),
    .wide (speed_fast),
    .dout (in_masked)
  );

  link_decode #(.DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_link    (state == ST_LINK),
    .ctl_in     (bus_ctl_i),
    .dat_masked (in_masked),
    .link_done  (link_done),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .link_err   (link_err)
  );

  assign rx_ready   = (state == ST_RECV);
  assign stat_ready = (state == ST_STAT);
  assign bus_oe     = (state != ST_LINK) && (state != ST_TURN);

  always_comb begin
    out_raw   = '0;
    bus_ctl_o = PHY_IDLE;
    unique case (state)
      ST_STAT: begin
        bus_ctl_o = PHY_STAT;
        if (stat_valid) out_raw = stat_data;
      end
      ST_RECV: begin
        bus_ctl_o = PHY_RECV;
        if (rx_valid) out_raw = rx_data;
      end
      ST_GRANT: bus_ctl_o = PHY_GRANT;
      default:  bus_ctl_o = PHY_IDLE;
    endcase
  end

  assign bus_dat_o = out_masked;

  assert_narrow_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !speed_fast) |-> (bus_dat_o[DATA_W-1:NARROW_W] == {HI_W{1'b0}}));

  assert_quiet_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && (bus_ctl_o == PHY_IDLE || bus_ctl_o == PHY_GRANT)) |-> (bus_dat_o == '0));

  assert_grant_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && bus_ctl_o == PHY_GRANT) |=> !bus_oe);

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LINK && bus_ctl_i == LNK_DONE) |=> !bus_oe ##1 bus_oe);

  assert_err_reclaim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |-> (!bus_oe ##1 bus_oe));

  assert_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (!rx_ready && !stat_ready));
endmodule

// File: tb/phy_ctl_arbiter_test.sv
`timescale 1ns/1ps
module phy_ctl_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_fast = 1'b0;
  logic       rx_valid = 1'b0, rx_last = 1'b0;
  logic [3:0] rx_data = '0;
  logic       stat_valid = 1'b0, stat_last = 1'b0;
  logic [3:0] stat_data = '0;
  logic       grant_req = 1'b0;
  logic [1:0] bus_ctl_i = '0;
  logic [3:0] bus_dat_i = '0;
  logic       rx_ready, stat_ready, bus_oe, tx_valid, link_err;
  logic [1:0] bus_ctl_o;
  logic [3:0] bus_dat_o, tx_data;

  int checks = 0;
  int errors = 0;
  int mst = 0;            // 0 idle 1 status 2 receive 3 grant 4 link 5 turn
  logic       exp_txv = 1'b0;
  logic [3:0] exp_txd = '0;
  logic       exp_err = 1'b0;
  int err_seen = 0;

  always #2 clk = ~clk;

  phy_ctl_arbiter uut (
    .clk(clk), .rst_n(rst_n), .speed_fast(speed_fast),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .stat_valid(stat_valid), .stat_ready(stat_ready), .stat_data(stat_data),
    .stat_last(stat_last), .grant_req(grant_req),
    .bus_ctl_o(bus_ctl_o), .bus_dat_o(bus_dat_o), .bus_oe(bus_oe),
    .bus_ctl_i(bus_ctl_i), .bus_dat_i(bus_dat_i),
    .tx_valid(tx_valid), .tx_data(tx_data), .link_err(link_err)
  );

  function automatic logic [3:0] msk(input logic [3:0] d, input logic f);
    return f ? d : {2'b00, d[1:0]};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic rl, input logic [3:0] rd,
                      input logic sv, input logic sl, input logic [3:0] sd,
                      input logic gr, input logic [1:0] ci, input logic [3:0] di,
                      input logic f);
    logic       e_oe;
    logic [1:0] e_ctl;
    logic [3:0] e_dat;
    int nst;
    @(posedge clk); #1;
    rx_valid = rv; rx_last = rl; rx_data = rd;
    stat_valid = sv; stat_last = sl; stat_data = sd;
    grant_req = gr; bus_ctl_i = ci; bus_dat_i = di; speed_fast = f;
    #1;
    e_oe  = (mst < 4);
    e_ctl = (mst == 1) ? 2'b01 : (mst == 2) ? 2'b10 : (mst == 3) ? 2'b11 : 2'b00;
    e_dat = (mst == 1 && sv) ? msk(sd, f) : (mst == 2 && rv) ? msk(rd, f) : 4'h0;
    chk(mst == 3 ? "R5" : mst == 5 ? "R7" : "R9", "bus_oe", int'(bus_oe), int'(e_oe));
    if (e_oe) begin
      chk("R3", "bus_ctl_o", int'(bus_ctl_o), int'(e_ctl));
      chk(f ? "R4" : "R2", "bus_dat_o", int'(bus_dat_o), int'(e_dat));
    end
    chk(mst >= 4 ? "R9" : "R4", "rx_ready", int'(rx_ready), int'(mst == 2));
    chk(mst >= 4 ? "R9" : "R4", "stat_ready", int'(stat_ready), int'(mst == 1));
    chk("R6", "tx_valid", int'(tx_valid), int'(exp_txv));
    if (exp_txv) chk("R6", "tx_data", int'(tx_data), int'(exp_txd));
    chk("R8", "link_err", int'(link_err), int'(exp_err));
    // model of the next cycle
    exp_txv = (mst == 4 && ci == 2'b10);
    exp_txd = msk(di, f);
    exp_err = (mst == 4 && ci == 2'b11);
    if (exp_err) err_seen++;
    case (mst)
      0: nst = rv ? 2 : sv ? 1 : gr ? 3 : 0;
      1: nst = (sv && sl) ? 0 : 1;
      2: nst = (rv && rl) ? 0 : 2;
      3: nst = 4;
      4: nst = (ci == 2'b00 || ci == 2'b11) ? 5 : 4;
      default: nst = 0;
    endcase
    mst = nst;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1394));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "bus_oe", int'(bus_oe), 1);
    chk("R1", "bus_ctl_o", int'(bus_ctl_o), 0);
    chk("R1", "bus_dat_o", int'(bus_dat_o), 0);
    chk("R1", "readies", int'(rx_ready) + int'(stat_ready), 0);
    chk("R1", "tx_valid/link_err", int'(tx_valid) + int'(link_err), 0);
    rst_n = 1'b1;
    // R3 priority: all pending, receive wins, then status, then grant
    step(1,1,4'hF, 1,1,4'hA, 1, 2'b00, 4'h0, 0);
    step(1,1,4'hF, 1,1,4'hA, 1, 2'b00, 4'h0, 0); // receive beat, narrow
    step(0,0,4'h0, 1,1,4'hA, 1, 2'b00, 4'h0, 1);
    step(0,0,4'h0, 1,1,4'hA, 1, 2'b00, 4'h0, 1); // status beat, wide
    step(0,0,4'h0, 0,0,4'h0, 1, 2'b00, 4'h0, 1); // idle -> grant
    step(0,0,4'h0, 0,0,4'h0, 0, 2'b00, 4'h0, 1); // grant cycle (R5)
    // R8 error straight after grant, R9 pending receive waits
    step(1,0,4'h3, 0,0,4'h0, 0, 2'b11, 4'h0, 1);
    step(1,0,4'h3, 0,0,4'h0, 0, 2'b00, 4'h0, 1); // turnaround
    step(1,1,4'h3, 0,0,4'h0, 0, 2'b00, 4'h0, 1); // idle, receive pending
    step(1,1,4'hC, 0,0,4'h0, 1, 2'b00, 4'h0, 1); // receive last
    step(0,0,4'h0, 0,0,4'h0, 1, 2'b00, 4'h0, 0);
    step(0,0,4'h0, 0,0,4'h0, 0, 2'b00, 4'h0, 0);
    // R6 narrow transmit then R7 release
    step(0,0,4'h0, 0,0,4'h0, 0, 2'b10, 4'hE, 0);
    step(0,0,4'h0, 0,0,4'h0, 0, 2'b01, 4'hF, 1);
    step(0,0,4'h0, 0,0,4'h0, 0, 2'b00, 4'h0, 1);
    step(0,0,4'h0, 0,0,4'h0, 0, 2'b00, 4'h0, 1);
    // constrained random
    for (int n = 0; n < 6000; n++) begin
      int r;
      logic [1:0] ci;
      r = $urandom_range(0, 99);
      ci = (r < 45) ? 2'b01 : (r < 85) ? 2'b10 : (r < 95) ? 2'b00 : 2'b11;
      step($urandom_range(0, 9) < 2, $urandom_range(0, 3) == 0, 4'($urandom),
           $urandom_range(0, 9) < 2, $urandom_range(0, 3) == 0, 4'($urandom),
           $urandom_range(0, 9) < 4, ci, 4'($urandom), 1'($urandom));
    end
    chk("R8", "link errors exercised", int'(err_seen > 2), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule